// File: doc/BRIEF.md
# Table-Driven Line Pointer with Discrete Output Latch

This block holds a small line pointer and a bank of discrete output lines. The pointer can be loaded, stepped up, stepped down or held. There is no adder. The stepped values come from a constant table that the current pointer value indexes directly. Each table entry holds four fields: the next-up value, the next-down value, a one-hot set mask and the inverted clear mask. The output latch uses those masks to raise or drop the line that the pointer selects. The top pointer value selects every line at once, so one operation can raise or drop all of them.

The same set mask also supplies three compare flags: pointer at zero, at thirteen and at the top value. A sequencer outside the block reads these flags to end loops. All pins are plain control and status pins. Nothing streams through the block, so it has no valid/ready handshake and applies no back-pressure. Every operation is accepted on the rising clock edge where it is presented.

Top module: `ptr_latch_top`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `ptr_q` is 0 and `lines_q` is all zeros.
- R2: With `ptr_op` = 2'b01, the edge stores `ptr_din` into `ptr_q`.
- R3: With `ptr_op` = 2'b10, the edge stores `ptr_q` plus one, and 15 wraps to 0.
- R4: With `ptr_op` = 2'b11, the edge stores `ptr_q` minus one, and 0 wraps to 15.
- R5: With `ptr_op` = 2'b00, `ptr_q` keeps its value.
- R6: With `line_op` = 2'b01 and pointer n in 0..14, the edge sets bit n of `lines_q` and leaves the other bits unchanged.
- R7: With `line_op` = 2'b10 and pointer n in 0..14, the edge clears bit n of `lines_q` and leaves the other bits unchanged.
- R8: With pointer 15, `line_op` = 2'b01 sets all 16 bits of `lines_q` and `line_op` = 2'b10 clears all 16.
- R9: With `line_op` = 2'b00 or 2'b11, `lines_q` keeps its value.
- R10: The flags follow the current pointer combinationally. `flag_zero` is high for pointer 0 or 15. `flag_thirteen` is high for pointer 13 or 15. `flag_top` is high only for pointer 15.
- R11: When a line operation and a pointer update fall on the same edge, the line operation uses the pointer value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptr_op | input | 2 | Pointer operation: 00 hold, 01 load, 10 up, 11 down |
| ptr_din | input | 4 | Value stored by a load |
| line_op | input | 2 | Line operation: 01 set selected, 10 clear selected, 00/11 none |
| ptr_q | output | 4 | Current pointer |
| lines_q | output | 16 | Discrete output lines |
| flag_zero | output | 1 | Set-mask bit 0 of the current entry |
| flag_thirteen | output | 1 | Set-mask bit 13 of the current entry |
| flag_top | output | 1 | Set-mask bit 15 of the current entry |

## Verification
The pointer update and the line operation can land on the same edge. In that case the latch must use the old pointer and the register must take the new one. The bench provokes this with vector rows that pair a step or a load with a set or a clear. Several of these rows cross the wrap points and the all-lines value 15. For each row, a model updates the lines from the pointer it held before the edge, and then moves its pointer. The bench compares `lines_q` with that model and compares `ptr_q` with a hand-written expected value.

// File: rtl/ptrlut_pkg.sv
package ptrlut_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'b00,
    PTR_LOAD = 2'b01,
    PTR_UP   = 2'b10,
    PTR_DOWN = 2'b11
  } ptr_op_e;

  typedef enum logic [1:0] {
    LINE_KEEP  = 2'b00,
    LINE_SET   = 2'b01,
    LINE_CLR   = 2'b10,
    LINE_IDLE  = 2'b11
  } line_op_e;

endpackage

// File: rtl/ptrlut_table.sv
module ptrlut_table #(
  parameter int PTR_W = 4
) (
  input  logic [PTR_W-1:0]        idx,
  output logic [PTR_W-1:0]        step_up,
  output logic [PTR_W-1:0]        step_dn,
  output logic [(1<<PTR_W)-1:0]   set_mask,
  output logic [(1<<PTR_W)-1:0]   clr_mask
);
  localparam int DEPTH   = 1 << PTR_W;
  localparam int ENTRY_W = 2 * PTR_W + 2 * DEPTH;

  // entry layout: {up, down, inverted clear mask, one-hot set mask}
  logic [ENTRY_W-1:0] rom [DEPTH];
  logic [ENTRY_W-1:0] entry;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [PTR_W-1:0] UP_V = PTR_W'((g + 1) % DEPTH);
    localparam logic [PTR_W-1:0] DN_V = PTR_W'((g + DEPTH - 1) % DEPTH);
    // top index selects every line
    localparam logic [DEPTH-1:0] OR_V = (g == DEPTH - 1) ? {DEPTH{1'b1}}
                                                         : (DEPTH'(1) << g);
    assign rom[g] = {UP_V, DN_V, ~OR_V, OR_V};
  end

  assign entry    = rom[idx];
  assign step_up  = entry[ENTRY_W-1 -: PTR_W];
  assign step_dn  = entry[2*DEPTH + PTR_W - 1 -: PTR_W];
  assign clr_mask = entry[2*DEPTH-1 -: DEPTH];
  assign set_mask = entry[DEPTH-1:0];
endmodule

// File: rtl/ptrlut_ptr_reg.sv
module ptrlut_ptr_reg
  import ptrlut_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [PTR_W-1:0] din,
  input  logic [PTR_W-1:0] step_up,
  input  logic [PTR_W-1:0] step_dn,
  output logic [PTR_W-1:0] q
);
  logic [PTR_W-1:0] nxt;

  always_comb begin
    unique case (ptr_op_e'(op))
      PTR_LOAD: nxt = din;
      PTR_UP:   nxt = step_up;
      PTR_DOWN: nxt = step_dn;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/ptrlut_line_latch.sv
module ptrlut_line_latch
  import ptrlut_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [LINES-1:0] set_mask,
  input  logic [LINES-1:0] clr_mask,
  output logic [LINES-1:0] q
);
  logic [LINES-1:0] nxt;

  always_comb begin
    unique case (line_op_e'(op))
      LINE_SET: nxt = q | set_mask;
      LINE_CLR: nxt = q & clr_mask;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/ptr_latch_top.sv
module ptr_latch_top #(
  parameter int PTR_W   = 4,
  parameter int MID_IDX = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              ptr_op,
  input  logic [PTR_W-1:0]        ptr_din,
  input  logic [1:0]              line_op,
  output logic [PTR_W-1:0]        ptr_q,
  output logic [(1<<PTR_W)-1:0]   lines_q,
  output logic                    flag_zero,
  output logic                    flag_thirteen,
  output logic                    flag_top
);
  localparam int LINES = 1 << PTR_W;

  logic [PTR_W-1:0] up_w, dn_w;
  logic [LINES-1:0] set_w, clr_w;

  ptrlut_table #(.PTR_W(PTR_W)) u_table (
    .idx      (ptr_q),
    .step_up  (up_w),
    .step_dn  (dn_w),
    .set_mask (set_w),
    .clr_mask (clr_w)
  );

  ptrlut_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (ptr_op),
    .din     (ptr_din),
    .step_up (up_w),
    .step_dn (dn_w),
    .q       (ptr_q)
  );

  // masks come from the pre-edge pointer
  ptrlut_line_latch #(.LINES(LINES)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (line_op),
    .set_mask (set_w),
    .clr_mask (clr_w),
    .q        (lines_q)
  );

  assign flag_zero     = set_w[0];
  assign flag_thirteen = set_w[MID_IDX];
  assign flag_top      = set_w[LINES-1];
endmodule

// File: rtl/ptr_latch_chk.sv
module ptr_latch_chk #(
  parameter int PTR_W   = 4,
  parameter int MID_IDX = 13
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            ptr_op,
  input logic [PTR_W-1:0]      ptr_din,
  input logic [1:0]            line_op,
  input logic [PTR_W-1:0]      ptr_q,
  input logic [(1<<PTR_W)-1:0] lines_q,
  input logic                  flag_zero,
  input logic                  flag_thirteen,
  input logic                  flag_top
);
  localparam int LINES = 1 << PTR_W;
  localparam logic [PTR_W-1:0] TOP = PTR_W'(LINES - 1);

  function automatic logic [LINES-1:0] pick(input logic [PTR_W-1:0] p);
    return (p == TOP) ? {LINES{1'b1}} : (LINES'(1) << p);
  endfunction

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (ptr_q == '0 && lines_q == '0)); // R1
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_op == 2'b01 |=> ptr_q == $past(ptr_din)); // R2
  AST_PTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_op == 2'b10 |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1)); // R3
  AST_PTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_op == 2'b11 |=> ptr_q == PTR_W'($past(ptr_q) - 1'b1)); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_op == 2'b00 |=> $stable(ptr_q)); // R5
  AST_LINE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    line_op == 2'b01 |=> lines_q == ($past(lines_q) | pick($past(ptr_q)))); // R6
  AST_LINE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    line_op == 2'b10 |=> lines_q == ($past(lines_q) & ~pick($past(ptr_q)))); // R7
  AST_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (line_op == 2'b01 && ptr_q == TOP) |=> &lines_q); // R8
  AST_ALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (line_op == 2'b10 && ptr_q == TOP) |=> lines_q == '0); // R8
  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_op == 2'b00 || line_op == 2'b11) |=> $stable(lines_q)); // R9
  AST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_zero == (ptr_q == '0 || ptr_q == TOP) &&
    flag_thirteen == (ptr_q == PTR_W'(MID_IDX) || ptr_q == TOP) &&
    flag_top == (ptr_q == TOP)); // R10
  AST_FLAG_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_top |-> (flag_zero && flag_thirteen)); // R10
endmodule

bind ptr_latch_top ptr_latch_chk #(.PTR_W(PTR_W), .MID_IDX(MID_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_op(ptr_op), .ptr_din(ptr_din),
  .line_op(line_op), .ptr_q(ptr_q), .lines_q(lines_q),
  .flag_zero(flag_zero), .flag_thirteen(flag_thirteen), .flag_top(flag_top)
);

// File: tb/ptr_latch_top_bench.sv
module ptr_latch_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ptr_op = 2'b00;
  logic [3:0]  ptr_din = 4'd0;
  logic [1:0]  line_op = 2'b00;
  logic [3:0]  ptr_q;
  logic [15:0] lines_q;
  logic        flag_zero, flag_thirteen, flag_top;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]  m_ptr;
  logic [15:0] m_lines;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_latch_top u_ptr_latch_top (
    .clk(clk), .rst_n(rst_n), .ptr_op(ptr_op), .ptr_din(ptr_din),
    .line_op(line_op), .ptr_q(ptr_q), .lines_q(lines_q),
    .flag_zero(flag_zero), .flag_thirteen(flag_thirteen), .flag_top(flag_top)
  );

  // row: {ptr_op, ptr_din, line_op, expected ptr after edge}
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b01, 4'd5,  2'b00, 4'd5},   // R2 load
    {2'b10, 4'd0,  2'b01, 4'd6},   // R11 set bit 5, step up
    {2'b10, 4'd0,  2'b01, 4'd7},   // set bit 6
    {2'b11, 4'd0,  2'b10, 4'd6},   // R4 clear bit 7 (already low)
    {2'b11, 4'd0,  2'b10, 4'd5},   // clear bit 6
    {2'b01, 4'd15, 2'b00, 4'd15},
    {2'b10, 4'd0,  2'b00, 4'd0},   // R3 wrap up
    {2'b11, 4'd0,  2'b01, 4'd15},  // R4 wrap down, set bit 0
    {2'b00, 4'd0,  2'b01, 4'd15},  // R8 all set
    {2'b10, 4'd0,  2'b10, 4'd0},   // R8 all clear with wrap
    {2'b01, 4'd13, 2'b01, 4'd13},  // R11 load plus set at old ptr 0
    {2'b00, 4'd0,  2'b11, 4'd13},  // R9 idle code 11
    {2'b10, 4'd0,  2'b01, 4'd14},  // set bit 13
    {2'b10, 4'd0,  2'b00, 4'd15},  // R9 code 00
    {2'b01, 4'd2,  2'b10, 4'd2},   // clear all at old ptr 15
    {2'b11, 4'd0,  2'b00, 4'd1}
  };

  function automatic logic [15:0] sel_mask(input logic [3:0] p);
    return (p == 4'd15) ? 16'hFFFF : (16'd1 << p);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    check(req, {29'd0, flag_zero, flag_thirteen, flag_top},
          {29'd0, (m_ptr == 4'd0 || m_ptr == 4'd15),
           (m_ptr == 4'd13 || m_ptr == 4'd15), (m_ptr == 4'd15)});
  endtask

  // drive at negedge, model the edge, check at the next negedge
  task automatic step(input logic [1:0] po, input logic [3:0] pd, input logic [1:0] lo);
    ptr_op = po; ptr_din = pd; line_op = lo;
    if (lo == 2'b01)      m_lines = m_lines | sel_mask(m_ptr);
    else if (lo == 2'b10) m_lines = m_lines & ~sel_mask(m_ptr);
    case (po)
      2'b01:   m_ptr = pd;
      2'b10:   m_ptr = m_ptr + 4'd1;
      2'b11:   m_ptr = m_ptr - 4'd1;
      default: m_ptr = m_ptr;
    endcase
    @(negedge clk);
    ptr_op = 2'b00; line_op = 2'b00;
  endtask

  initial begin
    m_ptr = 4'd0; m_lines = 16'd0;
    @(negedge clk);
    check("R1 ptr in reset", {28'd0, ptr_q}, 32'd0);
    check("R1 lines in reset", {16'd0, lines_q}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_flags("R10 flags at 0");

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][11:10], VEC[i][9:6], VEC[i][5:4]);
      check($sformatf("R11 ptr row %0d", i), {28'd0, ptr_q}, {28'd0, VEC[i][3:0]});
      check($sformatf("R6/R7 lines row %0d", i), {16'd0, lines_q}, {16'd0, m_lines});
      check_flags($sformatf("R10 flags row %0d", i));
    end

    // sweep every pointer value: flags, single-line set and clear
    for (int p = 0; p < 16; p++) begin
      step(2'b01, 4'(p), 2'b00);
      check_flags($sformatf("R10 sweep flags p=%0d", p));
      step(2'b00, 4'd0, 2'b01);
      check($sformatf("R6/R8 sweep set p=%0d", p), {16'd0, lines_q}, {16'd0, m_lines});
      check($sformatf("R5 sweep hold p=%0d", p), {28'd0, ptr_q}, p);
      step(2'b00, 4'd0, 2'b10);
      check($sformatf("R7/R8 sweep clear p=%0d", p), {16'd0, lines_q}, {16'd0, m_lines});
    end

    // up and down through the full wrap
    step(2'b01, 4'd15, 2'b01);
    for (int k = 0; k < 17; k++) begin
      step(2'b10, 4'd0, 2'b00);
      check("R3 up sweep", {28'd0, ptr_q}, {28'd0, m_ptr});
    end
    for (int k = 0; k < 17; k++) begin
      step(2'b11, 4'd0, 2'b00);
      check("R4 down sweep", {28'd0, ptr_q}, {28'd0, m_ptr});
    end
    check("R9 lines kept during stepping", {16'd0, lines_q}, 32'h0000FFFF);

    // asynchronous reset mid-run
    step(2'b01, 4'd9, 2'b00);
    #2 rst_n = 1'b0;
    #1;
    check("R1 async ptr", {28'd0, ptr_q}, 32'd0);
    check("R1 async lines", {16'd0, lines_q}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    m_ptr = 4'd0; m_lines = 16'd0;
    @(negedge clk);
    check_flags("R10 flags after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule